// File: doc/BRIEF.md
# Indexed General-Purpose I/O Port

This block provides 22 general-purpose pins, grouped in three banks numbered 10–17, 20–25 and 30–37. Software reaches the pin data through a pair of byte addresses on an 8-bit I/O bus. The even address holds an index register. The odd address gives access to the bank that the index selects. The pair can sit at one of four bus locations, and it can be switched off entirely. Both choices come from a port-select byte held in a separate configuration register space.

The same configuration space holds one byte per pin. Each byte makes the pin an input or an output, can invert its logical sense, and can hand the pin to an alternate function. The alternate-function routing is outside this block. A pin given away that way only raises its `pin_special` flag and releases its pad driver.

A small bus state machine answers each decoded access. The answer comes one cycle after the access. It has three states:

- `ST_IDLE`: no reply is pending.
- `ST_WR_ACK`: a decoded write was taken.
- `ST_RD_ACK`: a decoded read was taken, and the read data is valid.

The transitions are evaluated in every state:

- A decoded write moves to `ST_WR_ACK`.
- A decoded read without a write moves to `ST_RD_ACK`.
- Anything else returns to `ST_IDLE`.

Back-to-back accesses therefore get back-to-back replies.

Top module: `idx_gpio`

## Requirements
- R1: The port-select byte sits at configuration address 0x03. Bit 7 enables the pair and bits 1:0 choose its location: 0 gives 0xE0/0xE1, 1 gives 0xE2/0xE3, 2 gives 0xE4/0xE5 and 3 gives 0xEA/0xEB (index at the first address, data at the second). Reading the byte back returns bit 7 and bits 1:0 with all other bits 0, and its reset value is 0x00.
- R2: While bit 7 of the port-select byte is clear, or when the bus address matches neither address of the selected pair, an access gets no acknowledge and no read data, and a write changes nothing.
- R3: A decoded access raises `io_ack` in the next cycle. For a read, `io_rvalid` is also raised in the next cycle and `io_rdata` carries the value; outside that cycle `io_rdata` is 0. A write has priority over a simultaneous read. The index register reads back as written and resets to 0.
- R4: Index 1 selects pins 10–17 (bit n is pin 1n), index 2 selects pins 20–25 in bits 5:0 with bits 7:6 reading 0, and index 3 selects pins 30–37. Any other index reads 0, and writes to it change no pin.
- R5: The per-pin configuration bytes sit at 0xE0–0xE7 (pins 10–17), 0xE8–0xED (pins 20–25) and 0xF5–0xFC (pins 30–37). In each byte, bit 0 = input, bit 1 = invert and bit 3 = special. A byte reads back with its other bits 0, and an unmapped configuration address reads 0.
- R6: After reset, every pin configuration byte reads 0x01, every data latch is 0 and no pad is driven.
- R7: A pin with bit 0 and bit 3 clear drives its pad (`pad_oe` high) with the data latch XOR the invert bit. Its data bit reads back as the latch value.
- R8: A pin with bit 0 set and bit 3 clear is not driven. Its data bit reads as the pad level XOR the invert bit, sampled in the cycle of the read strobe.
- R9: A pin with bit 3 set raises `pin_special`, never drives its pad, and its data bit reads 0.
- R10: A data write updates only the latches of pins that are outputs (bit 0 and bit 3 clear). An input pin later turned into an output shows its old latch value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration-space write strobe |
| cfg_addr | input | 8 | Configuration-space address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, combinational from `cfg_addr` |
| io_addr | input | ADDR_W (16) | I/O bus address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_ack | output | 1 | Access acknowledged (one cycle after the access) |
| io_rvalid | output | 1 | Read data valid |
| io_rdata | output | 8 | Read data, 0 when not valid |
| pad_in | input | 22 | Pad levels, bit 0 = pin 10 … bit 21 = pin 37 |
| pad_out | output | 22 | Pad drive values |
| pad_oe | output | 22 | Pad output enables |
| pin_special | output | 22 | Alternate-function flag per pin |

## Verification
A corrupted data latch shows on `pad_out` in the cycle after the faulty write, as long as the pin is an output. On an input pin it stays hidden until that pin becomes an output or its bank is read. A wrong index or port-select state shows only at the next bus access: either the reply is missing, or it arrives with the wrong bank's data one cycle later. The bench therefore keeps a behavioural model of every latch, configuration byte and pending reply. It compares all pad outputs and the reply signals on every clock. This catches a bad internal state in the first cycle where it can reach a port.

// File: rtl/idx_gpio_pkg.sv
`timescale 1ns/1ps
package idx_gpio_pkg;
    localparam int DATA_W   = 8;
    localparam int BANK1_W  = 8;
    localparam int BANK2_W  = 6;
    localparam int BANK3_W  = 8;
    localparam int NPIN     = BANK1_W + BANK2_W + BANK3_W;
    localparam int B2_LO    = BANK1_W;
    localparam int B3_LO    = BANK1_W + BANK2_W;

    localparam logic [7:0] PORT_SEL_ADDR = 8'h03;
    localparam int CFG_IN  = 0;
    localparam int CFG_INV = 1;
    localparam int CFG_SPC = 3;

    typedef enum logic [1:0] {ST_IDLE, ST_WR_ACK, ST_RD_ACK} bus_state_e;

    // index value that selects the bank holding pin p
    function automatic int pin_bank(int p);
        if (p < B2_LO) return 1;
        if (p < B3_LO) return 2;
        return 3;
    endfunction

    function automatic int pin_bit(int p);
        if (p < B2_LO) return p;
        if (p < B3_LO) return p - B2_LO;
        return p - B3_LO;
    endfunction

    function automatic logic [7:0] pin_cfg_addr(int p);
        if (p < B2_LO) return 8'(32'hE0 + p);
        if (p < B3_LO) return 8'(32'hE8 + p - B2_LO);
        return 8'(32'hF5 + p - B3_LO);
    endfunction

    function automatic logic [7:0] pair_base(logic [1:0] sel);
        logic [7:0] b;
        unique case (sel)
            2'd0: b = 8'hE0;
            2'd1: b = 8'hE2;
            2'd2: b = 8'hE4;
            default: b = 8'hEA;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/idx_gpio_cfg.sv
`timescale 1ns/1ps
module idx_gpio_cfg
    import idx_gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              port_en,
    output logic [1:0]        port_sel,
    output logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_inv,
    output logic [NPIN-1:0]   pin_spc
);
    logic unused_bits;
    assign unused_bits = ^{cfg_wdata[6:4], cfg_wdata[2]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en  <= 1'b0;
            port_sel <= 2'd0;
        end else if (cfg_we && cfg_addr == PORT_SEL_ADDR) begin
            port_en  <= cfg_wdata[7];
            port_sel <= cfg_wdata[1:0];
        end
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pcfg
        localparam logic [7:0] MY_ADDR = pin_cfg_addr(g);
        logic in_q, inv_q, spc_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_q  <= 1'b1;
                inv_q <= 1'b0;
                spc_q <= 1'b0;
            end else if (cfg_we && cfg_addr == MY_ADDR) begin
                in_q  <= cfg_wdata[CFG_IN];
                inv_q <= cfg_wdata[CFG_INV];
                spc_q <= cfg_wdata[CFG_SPC];
            end
        end
        assign pin_in[g]  = in_q;
        assign pin_inv[g] = inv_q;
        assign pin_spc[g] = spc_q;
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == PORT_SEL_ADDR)
            cfg_rdata = {port_en, 5'b0, port_sel};
        for (int p = 0; p < NPIN; p++)
            if (cfg_addr == pin_cfg_addr(p))
                cfg_rdata = {4'b0, pin_spc[p], 1'b0, pin_inv[p], pin_in[p]};
    end
endmodule

// File: rtl/idx_gpio_pins.sv
`timescale 1ns/1ps
module idx_gpio_pins
    import idx_gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_in,
    input  logic [NPIN-1:0]   pin_inv,
    input  logic [NPIN-1:0]   pin_spc,
    input  logic              bank_we,
    input  logic [DATA_W-1:0] bank_idx,
    input  logic [DATA_W-1:0] bank_wdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pin_rd
);
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        localparam int MY_BANK = pin_bank(g);
        localparam int MY_BIT  = pin_bit(g);
        logic d_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                d_q <= 1'b0;
            else if (bank_we && bank_idx == DATA_W'(MY_BANK) && !pin_in[g] && !pin_spc[g])
                d_q <= bank_wdata[MY_BIT];
        end
        assign pad_out[g] = d_q ^ pin_inv[g];
        assign pad_oe[g]  = !pin_in[g] && !pin_spc[g];
        assign pin_rd[g]  = pin_spc[g] ? 1'b0
                          : pin_in[g]  ? (pad_in[g] ^ pin_inv[g])
                          :              d_q;
    end
endmodule

// File: rtl/idx_gpio_bus.sv
`timescale 1ns/1ps
module idx_gpio_bus
    import idx_gpio_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [1:0]        port_sel,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [NPIN-1:0]   pin_rd,
    output logic              io_ack,
    output logic              io_rvalid,
    output logic [DATA_W-1:0] io_rdata,
    output logic              bank_we,
    output logic [DATA_W-1:0] bank_idx,
    output logic [DATA_W-1:0] bank_wdata
);
    logic [ADDR_W-1:0] idx_addr, dat_addr;
    logic              hit_idx, hit_dat;
    logic [DATA_W-1:0] idx_q, rdata_q, bank_val;
    bus_state_e        state_q, state_d;

    assign idx_addr = ADDR_W'(pair_base(port_sel));
    assign dat_addr = idx_addr | ADDR_W'(1);
    assign hit_idx  = port_en && io_addr == idx_addr;
    assign hit_dat  = port_en && io_addr == dat_addr;

    assign bank_we    = hit_dat && io_wr;
    assign bank_idx   = idx_q;
    assign bank_wdata = io_wdata;

    always_comb begin
        bank_val = '0;
        for (int p = 0; p < NPIN; p++)
            if (idx_q == DATA_W'(pin_bank(p)))
                bank_val[3'(pin_bit(p))] = pin_rd[p];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: same decision from every state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_WR_ACK, ST_RD_ACK: begin
                if ((hit_idx || hit_dat) && io_wr)      state_d = ST_WR_ACK;
                else if ((hit_idx || hit_dat) && io_rd) state_d = ST_RD_ACK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            rdata_q <= '0;
        end else if (io_wr) begin
            if (hit_idx) idx_q <= io_wdata;
        end else if (io_rd) begin
            if (hit_idx)      rdata_q <= idx_q;
            else if (hit_dat) rdata_q <= bank_val;
        end
    end

    // outputs
    always_comb begin
        io_ack    = 1'b0;
        io_rvalid = 1'b0;
        io_rdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WR_ACK: io_ack = 1'b1;
            ST_RD_ACK: begin
                io_ack    = 1'b1;
                io_rvalid = 1'b1;
                io_rdata  = rdata_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/idx_gpio.sv
`timescale 1ns/1ps
module idx_gpio
    import idx_gpio_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic              io_ack,
    output logic              io_rvalid,
    output logic [7:0]        io_rdata,
    input  logic [21:0]       pad_in,
    output logic [21:0]       pad_out,
    output logic [21:0]       pad_oe,
    output logic [21:0]       pin_special
);
    logic              port_en;
    logic [1:0]        port_sel;
    logic [NPIN-1:0]   pin_in, pin_inv, pin_spc, pin_rd;
    logic              bank_we;
    logic [DATA_W-1:0] bank_idx, bank_wdata;

    idx_gpio_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .port_en(port_en),
        .port_sel(port_sel), .pin_in(pin_in), .pin_inv(pin_inv), .pin_spc(pin_spc)
    );

    idx_gpio_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .port_sel(port_sel),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .pin_rd(pin_rd), .io_ack(io_ack), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
        .bank_we(bank_we), .bank_idx(bank_idx), .bank_wdata(bank_wdata)
    );

    idx_gpio_pins u_pins (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_inv(pin_inv),
        .pin_spc(pin_spc), .bank_we(bank_we), .bank_idx(bank_idx),
        .bank_wdata(bank_wdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pin_rd(pin_rd)
    );

    assign pin_special = pin_spc;
endmodule

// File: rtl/idx_gpio_chk.sv
`timescale 1ns/1ps
module idx_gpio_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_wr,
    input logic        io_rd,
    input logic        cfg_we,
    input logic        io_ack,
    input logic        io_rvalid,
    input logic [7:0]  io_rdata,
    input logic [21:0] pad_out,
    input logic [21:0] pad_oe,
    input logic [21:0] pin_special,
    input logic        port_en
);
    AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && !port_en) |=> !io_ack);                         // R2
    AST_RVALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |-> ($past(io_rd) && !$past(io_wr)));                      // R3
    AST_RVALID_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |-> io_ack);                                               // R3
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rvalid |-> io_rdata == 8'h00);                                   // R3
    AST_SPECIAL_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pin_special) == 22'h0);                                    // R9
    AST_PADS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(io_wr) && !$past(cfg_we)) |-> ($stable(pad_out) && $stable(pad_oe))); // R7
endmodule

bind idx_gpio idx_gpio_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .cfg_we(cfg_we),
    .io_ack(io_ack), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
    .pad_out(pad_out), .pad_oe(pad_oe), .pin_special(pin_special), .port_en(port_en)
);

// File: tb/idx_gpio_test.sv
`timescale 1ns/1ps
module idx_gpio_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic        io_ack, io_rvalid;
    logic [7:0]  io_rdata;
    logic [21:0] pad_in = 22'h0;
    logic [21:0] pad_out, pad_oe, pin_special;

    idx_gpio uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_ack(io_ack),
        .io_rvalid(io_rvalid), .io_rdata(io_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pin_special(pin_special)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_port, m_idx, m_rd;
    logic [7:0] m_cfg [22];
    logic       m_dat [22];
    logic       m_ack, m_rv;

    function automatic int bank_of(int p);
        return (p < 8) ? 1 : (p < 14) ? 2 : 3;
    endfunction
    function automatic int bit_of(int p);
        return (p < 8) ? p : (p < 14) ? p - 8 : p - 14;
    endfunction
    function automatic int caddr(int p);
        case (bank_of(p))
            1: return 'hE0 + bit_of(p);
            2: return 'hE8 + bit_of(p);
            default: return 'hF5 + bit_of(p);
        endcase
    endfunction
    function automatic int mbase();
        case (m_port[1:0])
            2'd0: return 'hE0;
            2'd1: return 'hE2;
            2'd2: return 'hE4;
            default: return 'hEA;
        endcase
    endfunction
    function automatic logic [7:0] mread_bank(int b);
        logic [7:0] v = 8'h00;
        for (int p = 0; p < 22; p++)
            if (bank_of(p) == b) begin
                if (m_cfg[p][3])      v[bit_of(p)] = 1'b0;
                else if (m_cfg[p][0]) v[bit_of(p)] = pad_in[p] ^ m_cfg[p][1];
                else                  v[bit_of(p)] = m_dat[p];
            end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_port <= 8'h00; m_idx <= 8'h00; m_rd <= 8'h00;
            m_ack <= 1'b0; m_rv <= 1'b0;
            for (int p = 0; p < 22; p++) begin
                m_cfg[p] <= 8'h01;
                m_dat[p] <= 1'b0;
            end
        end else begin
            m_ack <= 1'b0; m_rv <= 1'b0; m_rd <= 8'h00;
            if (cfg_we) begin
                if (cfg_addr == 8'h03) m_port <= cfg_wdata & 8'h83;
                for (int p = 0; p < 22; p++)
                    if (caddr(p) == int'(cfg_addr)) m_cfg[p] <= cfg_wdata & 8'h0B;
            end
            if (m_port[7] && (io_wr || io_rd) &&
                (int'(io_addr) == mbase() || int'(io_addr) == mbase() + 1)) begin
                m_ack <= 1'b1;
                if (io_wr) begin
                    if (int'(io_addr) == mbase()) m_idx <= io_wdata;
                    else
                        for (int p = 0; p < 22; p++)
                            if (bank_of(p) == int'(m_idx) && !m_cfg[p][0] && !m_cfg[p][3])
                                m_dat[p] <= io_wdata[bit_of(p)];
                end else begin
                    m_rv <= 1'b1;
                    m_rd <= (int'(io_addr) == mbase()) ? m_idx : mread_bank(int'(m_idx));
                end
            end
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [21:0] e_oe, e_out, e_spc;
            for (int p = 0; p < 22; p++) begin
                e_oe[p]  = !m_cfg[p][0] && !m_cfg[p][3];
                e_out[p] = m_dat[p] ^ m_cfg[p][1];
                e_spc[p] = m_cfg[p][3];
            end
            chk("R2 R3 io_ack", io_ack, m_ack);
            chk("R3 io_rvalid", io_rvalid, m_rv);
            chk("R4 R8 io_rdata", io_rdata, m_rd);
            chk("R7 R9 pad_oe", pad_oe, e_oe);
            chk("R7 pad_out", pad_out, e_out);
            chk("R9 pin_special", pin_special, e_spc);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic cfg_wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask
    task automatic cfg_chk(logic [7:0] a, logic [7:0] e, string tag);
        @(negedge clk); cfg_addr = a; #1;
        chk(tag, cfg_rdata, e);
    endtask
    task automatic bus_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk); io_addr = a; io_wr = 1'b1; io_wdata = d;
        @(negedge clk); io_wr = 1'b0;
    endtask
    task automatic bus_rd(logic [15:0] a, output logic [7:0] d, output logic v);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        @(negedge clk); io_rd = 1'b0; d = io_rdata; v = io_rvalid;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R3: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic v;
        repeat (4) @(negedge clk);
        chk("R6 reset pad_oe", pad_oe, 22'h0);
        rst_n = 1'b1;
        cfg_chk(8'hE0, 8'h01, "R6 cfg pin10");
        cfg_chk(8'hFC, 8'h01, "R6 cfg pin37");
        cfg_chk(8'hED, 8'h01, "R5 cfg pin25");
        cfg_chk(8'hEE, 8'h00, "R5 unmapped EE");
        cfg_chk(8'hF4, 8'h00, "R5 unmapped F4");
        cfg_chk(8'h03, 8'h00, "R1 port-select reset");

        // disabled port
        bus_wr(16'h00E0, 8'h01);
        bus_rd(16'h00E1, d, v);
        chk("R2 no reply while disabled", v, 1'b0);

        cfg_wr(8'h03, 8'hFF);
        cfg_chk(8'h03, 8'h83, "R1 port-select readback");
        cfg_wr(8'h03, 8'h80);

        // bank 1 setup
        cfg_wr(8'hE0, 8'h00); cfg_wr(8'hE1, 8'h02); cfg_wr(8'hE2, 8'h08);
        cfg_wr(8'hE3, 8'h01);
        for (int a = 'hE4; a <= 'hE7; a++) cfg_wr(8'(a), 8'h00);
        cfg_chk(8'hE2, 8'h08, "R5 special readback");
        cfg_wr(8'hFC, 8'hF7);
        cfg_chk(8'hFC, 8'h03, "R5 masked readback");
        pad_in = 22'h000008;

        bus_wr(16'h00E0, 8'h01);
        bus_wr(16'h00E1, 8'hA5);
        bus_rd(16'h00E1, d, v);
        chk("R8 bank1 read", d, 8'hA9);
        chk("R7 bank1 pad_out", pad_out[7:0], 8'hA3);
        chk("R7 bank1 pad_oe", pad_oe[7:0], 8'hF3);
        chk("R9 bank1 special", pin_special[7:0], 8'h04);
        bus_rd(16'h00E0, d, v);
        chk("R3 index readback", d, 8'h01);
        pad_in = 22'h000000;
        bus_rd(16'h00E1, d, v);
        chk("R8 input follows pad", d, 8'hA1);

        bus_wr(16'h00E1, 8'hFF);
        cfg_wr(8'hE3, 8'h00);
        bus_rd(16'h00E1, d, v);
        chk("R10 input latch untouched", d, 8'hF3);

        // bank 2
        for (int a = 'hE8; a <= 'hEC; a++) cfg_wr(8'(a), 8'h00);
        cfg_wr(8'hED, 8'h02);
        bus_wr(16'h00E0, 8'h02);
        bus_wr(16'h00E1, 8'hFF);
        bus_rd(16'h00E1, d, v);
        chk("R4 bank2 upper bits zero", d, 8'h3F);
        chk("R7 bank2 pad_out", pad_out[13:8], 6'h1F);

        // bank 3
        for (int a = 'hF5; a <= 'hF8; a++) cfg_wr(8'(a), 8'h03);
        for (int a = 'hF9; a <= 'hFB; a++) cfg_wr(8'(a), 8'h00);
        pad_in = {8'h85, 14'h0};
        bus_wr(16'h00E0, 8'h03);
        bus_wr(16'h00E1, 8'h5A);
        bus_rd(16'h00E1, d, v);
        chk("R8 bank3 inverted inputs", d, 8'h5A);

        // unused index
        bus_wr(16'h00E0, 8'h05);
        bus_wr(16'h00E1, 8'hFF);
        bus_rd(16'h00E1, d, v);
        chk("R4 unused index reads 0", d, 8'h00);
        bus_wr(16'h00E0, 8'h01);
        bus_rd(16'h00E1, d, v);
        chk("R4 unused index wrote nothing", d, 8'hF3);

        // relocation
        cfg_wr(8'h03, 8'h81);
        bus_wr(16'h00E0, 8'h02);
        bus_rd(16'h00E3, d, v);
        chk("R1 pair at E2/E3", d, 8'hF3);
        bus_rd(16'h00E1, d, v);
        chk("R2 old pair silent", v, 1'b0);
        cfg_wr(8'h03, 8'h82);
        bus_rd(16'h00E5, d, v);
        chk("R1 pair at E4/E5", d, 8'hF3);
        cfg_wr(8'h03, 8'h83);
        bus_rd(16'h00EB, d, v);
        chk("R1 pair at EA/EB", d, 8'hF3);
        bus_rd(16'h00EA, d, v);
        chk("R3 index at EA", d, 8'h01);
        bus_rd(16'h01EB, d, v);
        chk("R2 upper address bits decoded", v, 1'b0);

        // disable then re-enable
        cfg_wr(8'h03, 8'h03);
        bus_wr(16'h00EB, 8'h00);
        cfg_wr(8'h03, 8'h83);
        bus_rd(16'h00EB, d, v);
        chk("R2 disabled write ignored", d, 8'hF3);

        // special function on pin 10
        cfg_wr(8'hE0, 8'h09);
        bus_rd(16'h00EB, d, v);
        chk("R9 special reads 0", d, 8'hF2);
        chk("R9 special oe", pad_oe[0], 1'b0);
        chk("R9 special flag", pin_special[0], 1'b1);

        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule